// File: doc/BRIEF.md
# E1 Multiframe Transmit Framer

This block produces the serial 2048 kbit/s E1 line bit stream, one bit per clock, with the full 32-slot frame and the 16-frame signalling multiframe. Slot 0 and slot 16 of each frame are overhead. The block builds them from the alignment pattern, the alarm inputs, the externally computed check bit and a stored copy of the 30 four-bit signalling codes. The other thirty slots carry voice bytes that the block pulls from a payload port. Each byte is sent most significant bit first.

The payload port is a valid/ready stream with a fixed rate. The block raises `pay_ready` for exactly one clock, during the last bit period of every slot that comes just before a voice slot. A byte transfers when `pay_valid` is high in that cycle. The line cannot stall, so back-pressure only works one way: the source must have its byte valid when the offer is made. If it has none, the slot is filled with an idle byte. `pay_valid` has no effect in any other cycle. Strobes mark the first bit of every slot, of every frame and of every multiframe, as they appear on `ser_out`.

Top module: `e1_tx_framer`

## Requirements
- R1: While `rst_n` is low, `ser_out` is 1 and `slot_strb`, `frame_strb`, `mf_strb` and `pay_ready` are 0. The first rising edge after release puts bit 1 of slot 0 of frame 0 on `ser_out`.
- R2: `ser_out` advances one bit per clock. Each slot is 8 bits, sent MSB first (bit 1 = MSB). A frame is 32 slots and a multiframe is 16 frames. Slots 1–15 and 17–31 carry the accepted payload bytes in acceptance order.
- R3: `pay_ready` is high for one clock during the 8th bit period of each slot 0–14 and 16–30, and at no other time. A byte accepted there starts on `ser_out` two clocks later.
- R4: If `pay_valid` is low while `pay_ready` is high, the next voice slot carries `IDLE_BYTE` (default 8'hFF). `pay_valid` and `pay_data` are ignored while `pay_ready` is low.
- R5: In even frames, bits 2–8 of slot 0 are 0011011.
- R6: In odd frames, slot 0 bit 3 is `remote_alarm`, bit 6 is `aux_alarm`, and bits 2, 4, 5, 7 and 8 are 1.
- R7: Bit 1 of slot 0 in every frame equals `crc_bit`, sampled at the clock edge that puts that bit on `ser_out`.
- R8: In frame 0, slot 16 is 0000 in bits 1–4, 1 in bit 5, `mf_alarm` in bit 6, and 1 in bits 7–8.
- R9: In frame k (1–15), slot 16 carries the code of channel k in bits 1–4, then the code of channel k+15 in bits 5–8. Channel c (1–30) is `sig_codes[4c-1:4c-4]`, sent MSB first.
- R10: `sig_codes` is captured once per multiframe, at the edge that emits bit 1 of frame 0. Changes made later in the multiframe do not appear until the next one.
- R11: `slot_strb` is high with bit 1 of every slot on `ser_out`. `frame_strb` is high with bit 1 of slot 0. `mf_strb` is high with bit 1 of slot 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pay_data | input | 8 | Voice byte offered by the source |
| pay_valid | input | 1 | Source has a byte ready |
| pay_ready | output | 1 | One-cycle offer to take a byte for the next voice slot |
| sig_codes | input | 120 | Thirty 4-bit signalling codes, channel 1 in the low nibble |
| crc_bit | input | 1 | Value for bit 1 of slot 0 |
| remote_alarm | input | 1 | Remote frame-loss alarm, odd-frame slot 0 bit 3 |
| aux_alarm | input | 1 | Second alarm flag, odd-frame slot 0 bit 6 |
| mf_alarm | input | 1 | Multiframe-loss alarm, frame 0 slot 16 bit 6 |
| ser_out | output | 1 | Serial line data |
| slot_strb | output | 1 | First bit of a slot is on ser_out |
| frame_strb | output | 1 | First bit of a frame is on ser_out |
| mf_strb | output | 1 | First bit of a multiframe is on ser_out |

## Verification
The properties rely only on the free-running position count. They assume nothing about the payload, alarm, check-bit or signalling inputs beyond those inputs holding known values at each edge. The stimulus changes every input only on the falling clock edge. It randomises alarms, the check bit and `pay_valid` from a shift-register sequence, and it also drives `pay_valid` in cycles with no offer. It changes `sig_codes` in the middle of each multiframe, so a capture made at the wrong time would show up in the next frame's slot 16.

// File: rtl/e1f_pkg.sv
`timescale 1ns/1ps
package e1f_pkg;
  localparam int BIT_W    = 8;
  localparam int SLOT_N   = 32;
  localparam int FRAME_N  = 16;
  localparam int SIG_W    = 4;
  localparam int CHAN_N   = 30;
  localparam int HALF_CH  = CHAN_N / 2;
  localparam int BIT_CW   = $clog2(BIT_W);
  localparam int SLOT_CW  = $clog2(SLOT_N);
  localparam int FRAME_CW = $clog2(FRAME_N);
  localparam int SIGS_W   = CHAN_N * SIG_W;

  localparam logic [SLOT_CW-1:0] SIG_SLOT   = SLOT_CW'(16);
  localparam logic [BIT_W-2:0]   ALIGN_PAT  = 7'b0011011;

  typedef struct packed {
    logic [FRAME_CW-1:0] frame;
    logic [SLOT_CW-1:0]  slot;
    logic [BIT_CW-1:0]   bit_i;
  } pos_t;

  function automatic logic is_info(input logic [SLOT_CW-1:0] s);
    return (s != '0) && (s != SIG_SLOT);
  endfunction
endpackage

// File: rtl/e1f_position.sv
`timescale 1ns/1ps
module e1f_position
  import e1f_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output pos_t pos,
  output logic last_bit
);
  logic last_slot, last_frame;

  assign last_bit   = (pos.bit_i == BIT_CW'(BIT_W - 1));
  assign last_slot  = (pos.slot  == SLOT_CW'(SLOT_N - 1));
  assign last_frame = (pos.frame == FRAME_CW'(FRAME_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else begin
      pos.bit_i <= last_bit ? '0 : pos.bit_i + 1'b1;
      if (last_bit) begin
        pos.slot <= last_slot ? '0 : pos.slot + 1'b1;
        if (last_slot)
          pos.frame <= last_frame ? '0 : pos.frame + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e1f_payload.sv
`timescale 1ns/1ps
module e1f_payload
  import e1f_pkg::*;
#(
  parameter logic [BIT_W-1:0] IDLE_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pos_t             pos,
  input  logic             last_bit,
  input  logic [BIT_W-1:0] pay_data,
  input  logic             pay_valid,
  output logic             pay_ready,
  output logic [BIT_W-1:0] cur_byte
);
  logic [SLOT_CW-1:0] nxt_slot;

  assign nxt_slot  = (pos.slot == SLOT_CW'(SLOT_N - 1)) ? '0 : pos.slot + 1'b1;
  assign pay_ready = last_bit && is_info(nxt_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_byte <= IDLE_BYTE;
    else if (pay_ready)
      cur_byte <= pay_valid ? pay_data : IDLE_BYTE;
  end
endmodule

// File: rtl/e1f_overhead.sv
`timescale 1ns/1ps
module e1f_overhead
  import e1f_pkg::*;
(
  input  pos_t              pos,
  input  logic [SIGS_W-1:0] sig_snap,
  input  logic              crc_bit,
  input  logic              remote_alarm,
  input  logic              aux_alarm,
  input  logic              mf_alarm,
  output logic [BIT_W-1:0]  ovh_byte
);
  logic [FRAME_CW-1:0] fm1;
  int lo_a, lo_b;

  assign fm1  = pos.frame - 1'b1;
  assign lo_a = int'(fm1) * SIG_W;
  assign lo_b = (int'(fm1) + HALF_CH) * SIG_W;

  always_comb begin
    if (pos.slot == '0) begin
      if (!pos.frame[0])
        ovh_byte = {crc_bit, ALIGN_PAT};
      else
        ovh_byte = {crc_bit, 1'b1, remote_alarm, 2'b11, aux_alarm, 2'b11};
    end else if (pos.frame == '0) begin
      ovh_byte = {4'b0000, 1'b1, mf_alarm, 2'b11};
    end else begin
      ovh_byte = {sig_snap[lo_a +: SIG_W], sig_snap[lo_b +: SIG_W]};
    end
  end
endmodule

// File: rtl/e1_tx_framer.sv
`timescale 1ns/1ps
module e1_tx_framer
  import e1f_pkg::*;
#(
  parameter logic [BIT_W-1:0] IDLE_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BIT_W-1:0]  pay_data,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [SIGS_W-1:0] sig_codes,
  input  logic              crc_bit,
  input  logic              remote_alarm,
  input  logic              aux_alarm,
  input  logic              mf_alarm,
  output logic              ser_out,
  output logic              slot_strb,
  output logic              frame_strb,
  output logic              mf_strb
);
  pos_t              pos;
  logic              last_bit;
  logic [BIT_W-1:0]  cur_byte, ovh_byte, sel_byte;
  logic [SIGS_W-1:0] sig_snap;
  logic              slot_head, frame_head, mf_head;

  e1f_position u_pos (
    .clk(clk), .rst_n(rst_n), .pos(pos), .last_bit(last_bit)
  );

  e1f_payload #(.IDLE_BYTE(IDLE_BYTE)) u_pay (
    .clk(clk), .rst_n(rst_n), .pos(pos), .last_bit(last_bit),
    .pay_data(pay_data), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .cur_byte(cur_byte)
  );

  e1f_overhead u_ovh (
    .pos(pos), .sig_snap(sig_snap), .crc_bit(crc_bit),
    .remote_alarm(remote_alarm), .aux_alarm(aux_alarm),
    .mf_alarm(mf_alarm), .ovh_byte(ovh_byte)
  );

  assign slot_head  = (pos.bit_i == '0);
  assign frame_head = slot_head && (pos.slot == '0);
  assign mf_head    = frame_head && (pos.frame == '0);
  assign sel_byte   = is_info(pos.slot) ? cur_byte : ovh_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sig_snap <= '0;
    else if (mf_head)
      sig_snap <= sig_codes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_out    <= 1'b1;
      slot_strb  <= 1'b0;
      frame_strb <= 1'b0;
      mf_strb    <= 1'b0;
    end else begin
      ser_out    <= sel_byte[BIT_CW'(BIT_W - 1) - pos.bit_i];
      slot_strb  <= slot_head;
      frame_strb <= frame_head;
      mf_strb    <= mf_head;
    end
  end
endmodule

// File: rtl/e1f_checker.sv
`timescale 1ns/1ps
module e1f_checker (
  input logic clk,
  input logic rst_n,
  input logic ser_out,
  input logic slot_strb,
  input logic frame_strb,
  input logic mf_strb,
  input logic pay_ready
);
  logic [3:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (slot_strb) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 4'hF) begin
      gap <= gap + 1'b1;
    end
  end

  AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strb && seen) |-> (gap == 4'd7)); // R2

  AST_FRAME_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strb |-> slot_strb); // R11

  AST_MF_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    mf_strb |-> frame_strb); // R11

  AST_READY_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> ##2 slot_strb); // R3

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |=> !pay_ready); // R3

  AST_ALIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mf_strb |-> ##1 !ser_out ##1 !ser_out ##1 ser_out ##1 ser_out
                ##1 !ser_out ##1 ser_out ##1 ser_out); // R5
endmodule

bind e1_tx_framer e1f_checker i_chk (.*);

// File: tb/test_e1_tx_framer.sv
`timescale 1ns/1ps
module test_e1_tx_framer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   pay_data = '0;
  logic         pay_valid = 1'b0;
  logic         pay_ready;
  logic [119:0] sig_codes = '0;
  logic         crc_bit = 1'b0, remote_alarm = 1'b0, aux_alarm = 1'b0, mf_alarm = 1'b0;
  logic         ser_out, slot_strb, frame_strb, mf_strb;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  e1_tx_framer i_e1_tx_framer (
    .clk(clk), .rst_n(rst_n), .pay_data(pay_data), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .sig_codes(sig_codes), .crc_bit(crc_bit),
    .remote_alarm(remote_alarm), .aux_alarm(aux_alarm), .mf_alarm(mf_alarm),
    .ser_out(ser_out), .slot_strb(slot_strb), .frame_strb(frame_strb),
    .mf_strb(mf_strb)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit info_slot(input int s);
    return (s != 0) && (s != 16);
  endfunction

  // behavioural reference model
  int       pos_m = 0;
  bit       mvalid = 0;
  logic [7:0]   byte_m = 8'hFF;
  bit       idle_m = 1;
  logic [119:0] sig_m = '0;
  logic     e_ser, e_slot, e_frame, e_mf;
  string    tag_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      pos_m = 0; mvalid = 0; byte_m = 8'hFF; idle_m = 1;
    end else begin
      int fr, sl, bt;
      logic [7:0] b;
      fr = (pos_m / 256) % 16;
      sl = (pos_m / 8) % 32;
      bt = pos_m % 8;
      if (pos_m % 4096 == 0) sig_m = sig_codes;
      if (info_slot(sl)) begin
        b = byte_m; tag_m = idle_m ? "R4" : "R2";
      end else if (sl == 0) begin
        if (fr % 2 == 0) begin
          b = {crc_bit, 7'b0011011}; tag_m = (bt == 0) ? "R7" : "R5";
        end else begin
          b = {crc_bit, 1'b1, remote_alarm, 2'b11, aux_alarm, 2'b11};
          tag_m = (bt == 0) ? "R7" : "R6";
        end
      end else if (fr == 0) begin
        b = {4'b0000, 1'b1, mf_alarm, 2'b11}; tag_m = "R8";
      end else begin
        b = {sig_m[4*fr-1 -: 4], sig_m[4*(fr+15)-1 -: 4]};
        tag_m = (pos_m < 4096) ? "R9" : "R10";
      end
      e_ser   = b[7-bt];
      e_slot  = (bt == 0);
      e_frame = (bt == 0) && (sl == 0);
      e_mf    = e_frame && (fr == 0);
      if (bt == 7 && info_slot((sl + 1) % 32)) begin
        if (pay_valid) begin byte_m = pay_data; idle_m = 0; end
        else begin byte_m = 8'hFF; idle_m = 1; end
      end
      pos_m++;
      mvalid = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "pay_ready", pay_ready,
          (pos_m % 8 == 7) && info_slot(((pos_m / 8) + 1) % 32));
      if (mvalid) begin
        chk(tag_m, "ser_out", ser_out, e_ser);
        chk("R11", "slot_strb", slot_strb, e_slot);
        chk("R11", "frame_strb", frame_strb, e_frame);
        chk("R11", "mf_strb", mf_strb, e_mf);
      end
    end
  end

  task automatic set_sigs(input logic [3:0] seed);
    for (int c = 0; c < 30; c++) sig_codes[4*c +: 4] = 4'(c) ^ seed;
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    set_sigs(4'h3);
    repeat (3) begin
      @(negedge clk);
      chk("R1", "ser_out in reset", ser_out, 1'b1);
      chk("R1", "slot_strb in reset", slot_strb, 1'b0);
      chk("R1", "frame_strb in reset", frame_strb, 1'b0);
      chk("R1", "mf_strb in reset", mf_strb, 1'b0);
      chk("R1", "pay_ready in reset", pay_ready, 1'b0);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 3 * 4096 + 40; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pay_data     = lfsr[15:8] ^ 8'(c);
      crc_bit      = lfsr[2];
      remote_alarm = lfsr[3];
      aux_alarm    = lfsr[4];
      mf_alarm     = lfsr[5];
      if (c < 4096)      pay_valid = 1'b1;
      else if (c < 8192) pay_valid = lfsr[0];
      else               pay_valid = lfsr[0] & lfsr[1];
      if (c == 2000)  set_sigs(4'hA);
      if (c == 6000)  set_sigs(4'h5);
      if (c == 10000) set_sigs(4'hC);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog run did not complete act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule